// File: doc/BRIEF.md
# Line-Adaptive Hopping PWM Cycle Oscillator

This block sets the switching-cycle timing of a flyback power-supply controller. Each cycle it starts a gate pulse and emits a one-clock cycle-start strobe. The pulse ends when the external comparators request turn-off, subject to a minimum on-time. If no request arrives, the pulse ends at a maximum duty limit. The comparators, the slope generator and the analog front end sit outside the block.

The cycle length comes from one of two base frequencies, 140 kHz or 85 kHz. The choice is made from a digitized line-current code, which is read only while the gate is on. The selection has hysteresis and moves only in constant-voltage mode. In constant-current mode the last choice is kept. A slow stepped-triangle dither is added to the base period to spread the switching spectrum. The dither is deeper in the 85 kHz range. A new period, dither offset and duty limit take effect only at a cycle boundary, so a pulse is never cut short by a period change.

With the default 50 MHz clock the nominal periods are 357 and 588 clocks. The dither deviations are 10 and 48 clocks, the minimum on-time is 27 clocks, and the dither pattern repeats every 2.54 ms.

Top module: `hop_pwm_osc`

## Requirements
- R1: While reset is low, `gate_o` and `cyc_start_o` are 0 and the block starts in the 140 kHz range. The first cycle starts on the first clock edge after reset is released.
- R2: In the 140 kHz range every period lies in [P-D, P+D]. P is floor(CLK_KHZ/140) and D is floor(P*4/140).
- R3: The block switches to the 85 kHz range when the line code is strictly above UP_THR (default 750), provided `gate_o` is 1 and `cv_mode_i` is 1 at that clock edge. In that range P is floor(CLK_KHZ/85) and D is floor(P*7/85). The new range applies from the next cycle boundary.
- R4: Hysteresis. A line code from DOWN_THR (680) to UP_THR (750) inclusive leaves the range unchanged. A code strictly below DOWN_THR selects the 140 kHz range.
- R5: The line code is ignored while `gate_o` is 0.
- R6: While `cv_mode_i` is 0 the range is held, whatever the line code.
- R7: The dither is a stepped triangle over one hop period of HOP_PERIOD_US. Over a full hop period the measured cycle lengths reach exactly P-D and exactly P+D of the current range.
- R8: With no turn-off request the gate stays high for floor(T*DUTY_PERMIL/1000) clocks, where T is that cycle's period and DUTY_PERMIL defaults to 685.
- R9: A turn-off request first seen at count c of a cycle, where c+1 >= MIN_ON, gives a pulse of c+1 clocks. Count 0 is the clock of the strobe.
- R10: A request seen before MIN_ON-1 is held, and the pulse lasts exactly MIN_ON clocks. MIN_ON is floor(CLK_KHZ*550/1e6).
- R11: `cyc_start_o` is a one-clock strobe that coincides with the first clock of the gate pulse. The period changes only at such a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_code_i | input | LINE_W | Digitized line current, in microamps |
| cv_mode_i | input | 1 | 1 = constant-voltage regulation, 0 = constant-current |
| off_req_i | input | 1 | Turn-off request from the PWM comparators |
| gate_o | output | 1 | Gate enable |
| cyc_start_o | output | 1 | One-clock strobe at the start of each cycle |

## Verification
The bench targets the boundary codes 750 and 680, where a design with an off-by-one comparison would switch range when it should hold. It drives a high code only while the gate is low; a selector that does not qualify on conduction would then drift to 85 kHz. It also checks that constant-current mode freezes the range. It sweeps a full hop period in each range and requires the exact extreme periods, which catches wrong depth scaling or a triangle that skips its end steps. Turn-off requests placed before, at and after the minimum on-time boundary catch a pulse that is truncated early or stretched one clock too far. The no-request duty is compared against each measured period, which catches a limit that is not latched at the cycle boundary.

// File: rtl/hoposc_pkg.sv
// Shared types for the hopping PWM oscillator.
package hoposc_pkg;
    // Frequency range selected from line current.
    typedef enum logic {
        BAND_FAST = 1'b0,   // low line, higher switching frequency
        BAND_SLOW = 1'b1    // high line, lower switching frequency
    } line_band_t;
endpackage

// File: rtl/line_band_sel.sv
// Line band selector.
// Chooses the frequency range from the line-current code, using hysteresis.
// Assumes gate_i is the registered gate, so the code is only read while the
// switch conducts. In CC mode the current range is held.
module line_band_sel
    import hoposc_pkg::*;
#(
    parameter int LINE_W   = 10,
    parameter int UP_THR   = 750,
    parameter int DOWN_THR = 680
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] code_i,
    input  logic              gate_i,
    input  logic              cv_i,
    output line_band_t        band_o
);
    localparam logic [LINE_W-1:0] UP_C   = LINE_W'(UP_THR);
    localparam logic [LINE_W-1:0] DOWN_C = LINE_W'(DOWN_THR);

    line_band_t band_q;

    // Update the range only during conduction in CV mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q <= BAND_FAST;
        end else if (gate_i && cv_i) begin
            if (code_i > UP_C) begin
                band_q <= BAND_SLOW;
            end else if (code_i < DOWN_C) begin
                band_q <= BAND_FAST;
            end
        end
    end

    assign band_o = band_q;

    // R5 / R6: no range change unless conducting in CV mode.
    p_band_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_i && cv_i) |=> $stable(band_q));

    // R3: a code above the upper threshold selects the slow range.
    p_band_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && cv_i && code_i > UP_C) |=> band_q == BAND_SLOW);

    // R4: a code below the lower threshold selects the fast range.
    p_band_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && cv_i && code_i < DOWN_C) |=> band_q == BAND_FAST);
endmodule

// File: rtl/hop_dither.sv
// Hop dither generator.
// Produces a stepped triangle position from 0 to 2*STEPS and back. Each step
// is held for DWELL_CLKS clocks, so one full sweep takes 4*STEPS dwells.
// The output is the offset from the centre as a magnitude plus a sign.
// Assumes STEPS >= 1 and DWELL_CLKS >= 2.
module hop_dither #(
    parameter int STEPS      = 8,
    parameter int DWELL_CLKS = 3968,
    localparam int POS_W     = $clog2(2*STEPS+1),
    localparam int MAG_W     = $clog2(STEPS+1),
    localparam int DW_W      = $clog2(DWELL_CLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [MAG_W-1:0] mag_o,
    output logic             up_o
);
    localparam logic [POS_W-1:0] TOP_POS = POS_W'(2*STEPS);
    localparam logic [POS_W-1:0] MID_POS = POS_W'(STEPS);
    localparam logic [DW_W-1:0]  DW_LAST = DW_W'(DWELL_CLKS-1);

    logic [DW_W-1:0]  dw_q;
    logic [POS_W-1:0] pos_q;
    logic             rising_q;

    // Advance the triangle one step at the end of each dwell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_q     <= '0;
            pos_q    <= MID_POS;
            rising_q <= 1'b1;
        end else if (dw_q == DW_LAST) begin
            dw_q <= '0;
            if (rising_q) begin
                if (pos_q == TOP_POS) begin
                    rising_q <= 1'b0;
                    pos_q    <= pos_q - 1'b1;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end else begin
                if (pos_q == '0) begin
                    rising_q <= 1'b1;
                    pos_q    <= POS_W'(1);
                end else begin
                    pos_q <= pos_q - 1'b1;
                end
            end
        end else begin
            dw_q <= dw_q + 1'b1;
        end
    end

    // Split the position into sign and distance from the centre.
    always_comb begin
        up_o  = (pos_q >= MID_POS);
        mag_o = up_o ? MAG_W'(pos_q - MID_POS) : MAG_W'(MID_POS - pos_q);
    end

    // R7: the triangle never leaves its range.
    p_pos_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= TOP_POS);

    // R7: the position moves by at most one step per clock.
    p_pos_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(pos_q) |-> ($past(dw_q) == DW_LAST));
endmodule

// File: rtl/pwm_cycle_timer.sv
// PWM cycle timer.
// Counts each period and latches the period and duty limit at every cycle
// boundary. It raises the gate with a start strobe and drops it on a
// turn-off request once the minimum on-time has passed, or at the duty limit.
// Assumes MIN_ON_CLK <= duty limit < period.
module pwm_cycle_timer #(
    parameter int PER_W       = 10,
    parameter int MIN_ON_CLK  = 27,
    parameter int DUTY_PERMIL = 685
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] next_per_i,
    input  logic             off_req_i,
    output logic             gate_o,
    output logic             start_o
);
    localparam int PROD_W = PER_W + 11;
    localparam logic [PER_W-1:0] MIN_LAST = PER_W'(MIN_ON_CLK-1);

    logic             running_q;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] maxon_q;
    logic             gate_q;
    logic             start_q;
    logic             pend_q;

    logic [PROD_W-1:0] duty_prod;
    logic [PER_W-1:0]  maxon_next;
    logic              wrap;
    logic              kill;

    // Duty limit for the cycle about to start.
    always_comb begin
        duty_prod  = (PROD_W'(next_per_i) * PROD_W'(DUTY_PERMIL)) / PROD_W'(1000);
        maxon_next = PER_W'(duty_prod);
    end

    // Cycle boundary and gate termination decisions.
    always_comb begin
        wrap = !running_q || (cnt_q == per_q - 1'b1);
        kill = gate_q && ((((off_req_i || pend_q) && (cnt_q >= MIN_LAST)))
                          || (cnt_q == maxon_q - 1'b1));
    end

    // Cycle counter, gate and held request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            per_q     <= '0;
            maxon_q   <= '0;
            gate_q    <= 1'b0;
            start_q   <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wrap) begin
                running_q <= 1'b1;
                cnt_q     <= '0;
                per_q     <= next_per_i;
                maxon_q   <= maxon_next;
                gate_q    <= 1'b1;
                start_q   <= 1'b1;
                pend_q    <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (kill) begin
                    gate_q <= 1'b0;
                end
                if (gate_q && off_req_i) begin
                    pend_q <= 1'b1;
                end
            end
        end
    end

    assign gate_o  = gate_q;
    assign start_o = start_q;

    // R8: the gate is never high past the duty limit.
    p_max_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> cnt_q < maxon_q);

    // R10: a pulse is never shorter than the minimum on-time.
    p_min_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_q) |-> cnt_q >= PER_W'(MIN_ON_CLK));

    // R11: the strobe marks the first clock of the pulse.
    p_start_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (gate_q && cnt_q == '0));

    // R11: the period changes only at a cycle boundary.
    p_period_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |-> $stable(per_q));
endmodule

// File: rtl/hop_pwm_osc.sv
// Line-adaptive hopping PWM oscillator (top level).
// Combines the band selector, the dither generator and the cycle timer.
// Each cycle's period is the base period of the selected band plus the
// scaled dither offset, and the timer latches it at the cycle boundary.
// Assumes F_SLOW_KHZ < F_FAST_KHZ.
module hop_pwm_osc
    import hoposc_pkg::*;
#(
    parameter int CLK_KHZ       = 50000,
    parameter int F_FAST_KHZ    = 140,
    parameter int F_SLOW_KHZ    = 85,
    parameter int HOP_FAST_KHZ  = 4,
    parameter int HOP_SLOW_KHZ  = 7,
    parameter int HOP_PERIOD_US = 2540,
    parameter int HOP_STEPS     = 8,
    parameter int DUTY_PERMIL   = 685,
    parameter int MIN_ON_NS     = 550,
    parameter int LINE_W        = 10,
    parameter int UP_THR        = 750,
    parameter int DOWN_THR      = 680
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_code_i,
    input  logic              cv_mode_i,
    input  logic              off_req_i,
    output logic              gate_o,
    output logic              cyc_start_o
);
    localparam int PER_FAST   = CLK_KHZ / F_FAST_KHZ;
    localparam int PER_SLOW   = CLK_KHZ / F_SLOW_KHZ;
    localparam int DEV_FAST   = PER_FAST * HOP_FAST_KHZ / F_FAST_KHZ;
    localparam int DEV_SLOW   = PER_SLOW * HOP_SLOW_KHZ / F_SLOW_KHZ;
    localparam int PER_MAX    = PER_SLOW + DEV_SLOW;
    localparam int PER_W      = $clog2(PER_MAX + 1);
    localparam int MIN_ON_CLK = CLK_KHZ * MIN_ON_NS / 1000000;
    localparam int HOP_CLKS   = CLK_KHZ * HOP_PERIOD_US / 1000;
    localparam int DWELL_CLKS = HOP_CLKS / (4 * HOP_STEPS);
    localparam int MAG_W      = $clog2(HOP_STEPS + 1);
    localparam int PRW        = PER_W + MAG_W;

    line_band_t       band;
    logic [MAG_W-1:0] hop_mag;
    logic             hop_up;
    logic [PER_W-1:0] base_per;
    logic [PER_W-1:0] dev_clk;
    logic [PRW-1:0]   scaled;
    logic [PER_W-1:0] shift;
    logic [PER_W-1:0] next_per;
    logic             gate;

    line_band_sel #(
        .LINE_W  (LINE_W),
        .UP_THR  (UP_THR),
        .DOWN_THR(DOWN_THR)
    ) u_band (
        .clk   (clk),
        .rst_n (rst_n),
        .code_i(line_code_i),
        .gate_i(gate),
        .cv_i  (cv_mode_i),
        .band_o(band)
    );

    hop_dither #(
        .STEPS     (HOP_STEPS),
        .DWELL_CLKS(DWELL_CLKS)
    ) u_hop (
        .clk  (clk),
        .rst_n(rst_n),
        .mag_o(hop_mag),
        .up_o (hop_up)
    );

    // Base period and dither depth of the selected band.
    always_comb begin
        base_per = (band == BAND_SLOW) ? PER_W'(PER_SLOW) : PER_W'(PER_FAST);
        dev_clk  = (band == BAND_SLOW) ? PER_W'(DEV_SLOW) : PER_W'(DEV_FAST);
    end

    // Scale the triangle step to clocks and apply its sign.
    always_comb begin
        scaled   = (PRW'(hop_mag) * PRW'(dev_clk)) / PRW'(HOP_STEPS);
        shift    = PER_W'(scaled);
        next_per = hop_up ? (base_per + shift) : (base_per - shift);
    end

    pwm_cycle_timer #(
        .PER_W      (PER_W),
        .MIN_ON_CLK (MIN_ON_CLK),
        .DUTY_PERMIL(DUTY_PERMIL)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_per_i(next_per),
        .off_req_i (off_req_i),
        .gate_o    (gate),
        .start_o   (cyc_start_o)
    );

    assign gate_o = gate;

    // R2 / R7: the candidate period stays inside the band's dither window.
    p_period_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (next_per >= base_per - dev_clk) && (next_per <= base_per + dev_clk));
endmodule

// File: tb/test_hop_pwm_osc.sv
// Self-checking bench for hop_pwm_osc.
module test_hop_pwm_osc;
    localparam int CLK_KHZ  = 50000;
    localparam int HOP_US   = 400;
    localparam int STEPS    = 4;
    localparam int P_FAST   = CLK_KHZ / 140;
    localparam int D_FAST   = P_FAST * 4 / 140;
    localparam int P_SLOW   = CLK_KHZ / 85;
    localparam int D_SLOW   = P_SLOW * 7 / 85;
    localparam int MIN_ON   = CLK_KHZ * 550 / 1000000;
    localparam int HOP_CLKS = CLK_KHZ * HOP_US / 1000;

    // Table rows: {cv, code, expected band (1 = slow)}.
    localparam int NROWS = 12;
    localparam int ROW_CV   [NROWS] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 0};
    localparam int ROW_CODE [NROWS] = '{500, 751, 750, 700, 680, 679, 750, 720, 1000, 100, 300, 900};
    localparam int ROW_SLOW [NROWS] = '{0, 1, 1, 1, 1, 0, 0, 0, 1, 1, 0, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] line_code = 10'd0;
    logic       cv_mode = 1'b1;
    logic       off_req = 1'b0;
    logic       gate;
    logic       cyc_start;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    hop_pwm_osc #(
        .CLK_KHZ      (CLK_KHZ),
        .HOP_PERIOD_US(HOP_US),
        .HOP_STEPS    (STEPS)
    ) i_hop_pwm_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_code_i(line_code),
        .cv_mode_i  (cv_mode),
        .off_req_i  (off_req),
        .gate_o     (gate),
        .cyc_start_o(cyc_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_start();
        do @(negedge clk); while (!cyc_start);
    endtask

    // Called at the strobe negedge; returns at the next strobe negedge.
    task automatic measure(output int per, output int on);
        per = 0;
        on  = 0;
        do begin
            if (gate) on++;
            per++;
            @(negedge clk);
        end while (!cyc_start);
    endtask

    // Raise the request at count c and return the pulse length.
    task automatic pulse_req(input int c, output int on);
        wait_start();
        on = 0;
        for (int k = 0; k < 2000; k++) begin
            if (k == c) off_req = 1'b1;
            if (!gate) break;
            on++;
            @(negedge clk);
        end
        off_req = 1'b0;
    endtask

    task automatic band_check(input int slow, input string req);
        int per, on;
        wait_start();
        measure(per, on);
        measure(per, on);
        if (slow != 0)
            check(per >= P_SLOW - D_SLOW && per <= P_SLOW + D_SLOW, req, per, P_SLOW);
        else
            check(per >= P_FAST - D_FAST && per <= P_FAST + D_FAST, req, per, P_FAST);
        check(on == per * 685 / 1000, "R8 duty", on, per * 685 / 1000);
    endtask

    // Sweep a full hop period and compare the extreme periods.
    task automatic hop_sweep(input int p, input int d, input string req);
        int per, on, mn, mx, n;
        mn = 1 << 30;
        mx = 0;
        n  = 0;
        wait_start();
        while (n < HOP_CLKS + 2 * p) begin
            measure(per, on);
            n += per;
            if (per < mn) mn = per;
            if (per > mx) mx = per;
        end
        check(mn == p - d, req, mn, p - d);
        check(mx == p + d, req, mx, p + d);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int per, on, lat;
        // R1: reset state.
        repeat (5) begin
            @(negedge clk);
            check(gate == 1'b0 && cyc_start == 1'b0, "R1 reset outputs", {gate, cyc_start}, 0);
        end
        rst_n = 1'b1;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!cyc_start && lat < 10);
        check(lat == 1, "R1 first strobe latency", lat, 1);
        // R11: one-clock strobe with gate high.
        check(gate == 1'b1, "R11 gate at strobe", gate, 1);
        @(negedge clk);
        check(cyc_start == 1'b0 && gate == 1'b1, "R11 strobe width", cyc_start, 0);
        line_code = 10'd500;
        band_check(0, "R1 R2 initial fast band");

        // Table walk: R2, R3, R4, R6.
        for (int i = 0; i < NROWS; i++) begin
            cv_mode   = (ROW_CV[i] != 0);
            line_code = 10'(ROW_CODE[i]);
            band_check(ROW_SLOW[i], $sformatf("R3 R4 R6 row %0d band", i));
        end

        // R5: high code only while gate low must not switch the band.
        cv_mode = 1'b1;
        line_code = 10'd100;
        wait_start();
        for (int k = 0; k < 6 * P_FAST; k++) begin
            line_code = gate ? 10'd100 : 10'd900;
            @(negedge clk);
        end
        line_code = 10'd100;
        band_check(0, "R5 code ignored while gate low");

        // R7: dither extremes in both bands.
        hop_sweep(P_FAST, D_FAST, "R7 fast band hop extreme");
        line_code = 10'd900;
        band_check(1, "R3 enter slow band");
        hop_sweep(P_SLOW, D_SLOW, "R7 slow band hop extreme");
        line_code = 10'd100;
        band_check(0, "R4 back to fast band");

        // R9 / R10: turn-off request timing.
        pulse_req(100, on);
        check(on == 101, "R9 request ends pulse", on, 101);
        pulse_req(MIN_ON - 1, on);
        check(on == MIN_ON, "R9 request at min boundary", on, MIN_ON);
        pulse_req(MIN_ON, on);
        check(on == MIN_ON + 1, "R9 request just after min", on, MIN_ON + 1);
        pulse_req(0, on);
        check(on == MIN_ON, "R10 early request held", on, MIN_ON);
        pulse_req(MIN_ON - 2, on);
        check(on == MIN_ON, "R10 request before min", on, MIN_ON);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule